// File: doc/BRIEF.md
# Handshaked SPI Master Controller

This block is a SPI master that runs one serial transfer for each word it accepts on a write-side ready/valid handshake. It returns the bits it received on a separate read-side ready/valid handshake. Each transfer carries its own length, from one bit up to a fixed maximum. With the received word the block returns a mask that marks which bit positions are valid. The serial clock comes from the system clock through an integer divider. Chip select is active low, and the block sequences it so that a minimum lead time, a minimum data hold time and a minimum idle gap are always met. Those times are parameters in nanoseconds, and each is rounded up to whole system-clock cycles when the design is elaborated (at least one cycle each).

Several devices can sit side by side on one serial clock and one chip select. Each device has its own data-out and data-in lane, and all lanes shift in lockstep. The write word and the read word are flat vectors with one `MAX_BITS` slice per lane. Lane `l` uses bits `[l*MAX_BITS +: MAX_BITS]`.

A single state machine controls the sequence. Its states are:
- `ST_IDLE`: chip select is high and write ready is high.
- `ST_LEAD`: chip select is low and the clock is still high.
- `ST_LOW`: the clock is low.
- `ST_HIGH`: the clock is high.
- `ST_GAP`: chip select is high and the idle time is counted.
- `ST_RESP`: read valid is high.

Its transitions are:
- `ST_IDLE`→`ST_LEAD` on a write handshake.
- `ST_LEAD`→`ST_LOW` when the lead time expires.
- `ST_LOW`→`ST_HIGH` when the low phase expires.
- `ST_HIGH`→`ST_LOW` when the high phase expires and bits remain.
- `ST_HIGH`→`ST_GAP` when the high phase expires after the last bit.
- `ST_GAP`→`ST_RESP` when the idle time expires.
- `ST_RESP`→`ST_IDLE` on a read handshake.

Top module: `spi_hs_master`

## Requirements
- R1: A transfer starts only on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_data` and `wr_len` are captured on that edge. On the next cycle `wr_ready` is low and `cs_n` is low.
- R2: While `rd_valid` is high and `rd_ready` is low, `rd_valid`, `rd_data` and `rd_mask` stay unchanged. `wr_ready` is never high while `rd_valid` is high. `wr_ready` stays low from acceptance until the read handshake completes.
- R3: `sclk` idles high whenever `cs_n` is high. Each low phase is `DIV/2` system cycles (at least 2), where `DIV = CLK_HZ/SCLK_HZ` must be at least 4. Each clock period lasts at least `1/SCLK_HZ`.
- R4: The effective length L is `wr_len` when it lies in 1..`MAX_BITS`. A `wr_len` of 0 gives L = 1, and a `wr_len` above `MAX_BITS` gives L = `MAX_BITS`. Exactly L rising edges of `sclk` occur while `cs_n` is low.
- R5: On every lane, the bits of the write slice are sent most significant first, from bit L-1 down to bit 0. `sdo` changes only in the cycle in which `sclk` falls.
- R6: Each `sdi` bit is sampled on a rising edge of `sclk` and stored at the same bit position as the bit sent on that edge, from L-1 down to 0. Read bits at position L and above are 0.
- R7: `rd_mask` has bits 0..L-1 set and all other bits clear, so bit 0 is set and the set bits are contiguous.
- R8: The time from `cs_n` falling to the first falling edge of `sclk` is at least `LEAD_NS`.
- R9: `sdo` stays unchanged for at least `HOLD_NS` after each rising edge of `sclk`. The high phase is stretched when the hold time exceeds half a period.
- R10: The time from the last rising edge of `sclk` in one transfer to the next falling edge of `cs_n` is at least `GAP_NS`.
- R11: All lanes share `sclk` and `cs_n`. Each lane shifts its own data in lockstep with the others.
- R12: Reset is synchronous and active high. After reset the block is idle, with `cs_n`=1, `sclk`=1, `rd_valid`=0 and `wr_ready`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write word and length are valid |
| wr_ready | output | 1 | Block can accept a new transfer |
| wr_len | input | $clog2(MAX_BITS+1) | Requested bit count |
| wr_data | input | LANES*MAX_BITS | Write words, one slice per lane |
| rd_valid | output | 1 | Received words and mask are valid |
| rd_ready | input | 1 | Downstream accepts the received words |
| rd_data | output | LANES*MAX_BITS | Received words, one slice per lane |
| rd_mask | output | MAX_BITS | Valid-bit mask for the received words |
| sclk | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Shared chip select, active low |
| sdi | input | LANES | Serial data in, one bit per lane |
| sdo | output | LANES | Serial data out, one bit per lane |

## Verification
The assertions check these rules on every cycle:
- A write handshake moves the block straight into an asserted chip select.
- The read output holds steady under back-pressure.
- Write ready and read valid never overlap.
- The clock idles high and each low phase spans at least two cycles.
- Serial output moves only with a falling clock.
- The mask is always a contiguous run starting at bit 0.

Only the bench scenarios can show the following:
- Each lane sends the right bits in the right order.
- Received bits land in the right positions.
- Lengths of 0 and above the maximum are clamped.
- The lead, hold, gap and period times are met in absolute time.

// File: rtl/spi_hs_pkg.sv
package spi_hs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_GAP,
        ST_RESP
    } spi_state_e;

    // Whole system cycles covering a time in ns, rounded up, never below one.
    function automatic int ns_to_cycles(input longint ns, input longint hz);
        longint c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/spi_hs_phase_timer.sv
module spi_hs_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/spi_hs_lane.sv
module spi_hs_lane #(
    parameter int MAX_BITS = 16,
    parameter int IW       = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [MAX_BITS-1:0] wdata,
    input  logic                drive_en,
    input  logic [IW-1:0]       drive_idx,
    input  logic                sample_en,
    input  logic [IW-1:0]       sample_idx,
    input  logic                sdi,
    output logic                sdo,
    output logic [MAX_BITS-1:0] rdata
);
    logic [MAX_BITS-1:0] tx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q  <= '0;
            rdata <= '0;
            sdo   <= 1'b0;
        end else begin
            if (load) begin
                tx_q  <= wdata;
                rdata <= '0;
            end
            if (drive_en)
                sdo <= tx_q[drive_idx];
            if (sample_en)
                rdata[sample_idx] <= sdi;
        end
    end
endmodule

// File: rtl/spi_hs_len_mask.sv
module spi_hs_len_mask #(
    parameter int MAX_BITS = 16,
    parameter int LW       = 5
) (
    input  logic [LW-1:0]       len,
    output logic [MAX_BITS-1:0] mask
);
    for (genvar i = 0; i < MAX_BITS; i++) begin : g_bit
        assign mask[i] = (i < int'(len));
    end
endmodule

// File: rtl/spi_hs_master.sv
module spi_hs_master
    import spi_hs_pkg::*;
#(
    parameter int CLK_HZ   = 125_000_000,
    parameter int SCLK_HZ  = 12_500_000,
    parameter int MAX_BITS = 16,
    parameter int LANES    = 2,
    parameter int LEAD_NS  = 20,
    parameter int HOLD_NS  = 50,
    parameter int GAP_NS   = 100,
    localparam int LW      = $clog2(MAX_BITS + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_valid,
    output logic                      wr_ready,
    input  logic [LW-1:0]             wr_len,
    input  logic [LANES*MAX_BITS-1:0] wr_data,
    output logic                      rd_valid,
    input  logic                      rd_ready,
    output logic [LANES*MAX_BITS-1:0] rd_data,
    output logic [MAX_BITS-1:0]       rd_mask,
    output logic                      sclk,
    output logic                      cs_n,
    input  logic [LANES-1:0]          sdi,
    output logic [LANES-1:0]          sdo
);
    localparam int DIV_C  = CLK_HZ / SCLK_HZ;
    localparam int LO_C   = DIV_C / 2;
    localparam int HOLD_C = ns_to_cycles(HOLD_NS, CLK_HZ);
    localparam int HI_C   = max_int(DIV_C - LO_C, HOLD_C);
    localparam int LEAD_C = ns_to_cycles(LEAD_NS, CLK_HZ);
    localparam int GAP_C  = ns_to_cycles(GAP_NS, CLK_HZ);
    localparam int TMAX   = max_int(max_int(LO_C, HI_C), max_int(LEAD_C, GAP_C));
    localparam int CW     = $clog2(TMAX + 1);
    localparam int IW     = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;

    if (DIV_C < 4) begin : g_div_chk
        $error("serial clock must be at most a quarter of the system clock");
    end

    spi_state_e    state, nstate;
    logic          tmr_load, tmr_done;
    logic [CW-1:0] tmr_val;
    logic [LW-1:0] len_eff, len_q;
    logic [IW-1:0] idx_q, drive_idx;
    logic          accept, last_bit, drive_en, sample_en;

    assign accept   = (state == ST_IDLE) && wr_valid;
    assign last_bit = (idx_q == '0);

    // Clamp the requested length into 1..MAX_BITS.
    always_comb begin
        if (wr_len == '0)
            len_eff = LW'(1);
        else if (wr_len > LW'(MAX_BITS))
            len_eff = LW'(MAX_BITS);
        else
            len_eff = wr_len;
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nstate;
    end

    // Next state and phase timer reload
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: if (wr_valid)              nstate = ST_LEAD;
            ST_LEAD: if (tmr_done)              nstate = ST_LOW;
            ST_LOW:  if (tmr_done)              nstate = ST_HIGH;
            ST_HIGH: if (tmr_done)              nstate = last_bit ? ST_GAP : ST_LOW;
            ST_GAP:  if (tmr_done)              nstate = ST_RESP;
            ST_RESP: if (rd_ready)              nstate = ST_IDLE;
            default:                            nstate = ST_IDLE;
        endcase
        tmr_load = (nstate != state);
        unique case (nstate)
            ST_LEAD: tmr_val = CW'(LEAD_C - 1);
            ST_LOW:  tmr_val = CW'(LO_C - 1);
            ST_HIGH: tmr_val = CW'(HI_C - 1);
            ST_GAP:  tmr_val = CW'(GAP_C - 1);
            default: tmr_val = '0;
        endcase
    end

    // Outputs decoded from the state register
    always_comb begin
        wr_ready = (state == ST_IDLE);
        rd_valid = (state == ST_RESP);
        cs_n     = !((state == ST_LEAD) || (state == ST_LOW) || (state == ST_HIGH));
        sclk     = (state != ST_LOW);
    end

    // Bit index and latched length
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            len_q <= LW'(1);
        end else if (accept) begin
            idx_q <= IW'(len_eff - LW'(1));
            len_q <= len_eff;
        end else if (state == ST_HIGH && nstate == ST_LOW) begin
            idx_q <= idx_q - IW'(1);
        end
    end

    assign drive_en  = ((state == ST_LEAD) || (state == ST_HIGH)) && (nstate == ST_LOW);
    assign drive_idx = (state == ST_LEAD) ? idx_q : idx_q - IW'(1);
    assign sample_en = (state == ST_LOW) && (nstate == ST_HIGH);

    spi_hs_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        spi_hs_lane #(.MAX_BITS(MAX_BITS), .IW(IW)) u_lane (
            .clk        (clk),
            .rst        (rst),
            .load       (accept),
            .wdata      (wr_data[l*MAX_BITS +: MAX_BITS]),
            .drive_en   (drive_en),
            .drive_idx  (drive_idx),
            .sample_en  (sample_en),
            .sample_idx (idx_q),
            .sdi        (sdi[l]),
            .sdo        (sdo[l]),
            .rdata      (rd_data[l*MAX_BITS +: MAX_BITS])
        );
    end

    spi_hs_len_mask #(.MAX_BITS(MAX_BITS), .LW(LW)) u_mask (
        .len  (len_q),
        .mask (rd_mask)
    );
endmodule

// File: rtl/spi_hs_master_chk.sv
module spi_hs_master_chk #(
    parameter int MAX_BITS = 16,
    parameter int LANES    = 2
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      wr_valid,
    input logic                      wr_ready,
    input logic                      rd_valid,
    input logic                      rd_ready,
    input logic [LANES*MAX_BITS-1:0] rd_data,
    input logic [MAX_BITS-1:0]       rd_mask,
    input logic                      sclk,
    input logic                      cs_n,
    input logic [LANES-1:0]          sdo
);
    // R1
    accept_to_lead_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid && wr_ready |=> !wr_ready && !cs_n);

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && $stable(rd_mask));

    // R2
    ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_ready && rd_valid));

    // R3
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);

    // R3
    low_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |=> !sclk);

    // R5
    sdo_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdo) |-> $fell(sclk));

    // R7
    mask_shape_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> rd_mask[0] && ((rd_mask & (rd_mask + MAX_BITS'(1))) == '0));

    // R12
    idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> cs_n && sclk);
endmodule

bind spi_hs_master spi_hs_master_chk #(.MAX_BITS(MAX_BITS), .LANES(LANES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .rd_mask  (rd_mask),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .sdo      (sdo)
);

// File: tb/spi_hs_master_bench.sv
`timescale 1ns/1ps
module spi_hs_master_bench;
    localparam int CLK_HZ  = 125_000_000;
    localparam int SCLK_HZ = 12_500_000;
    localparam int MAXB    = 16;
    localparam int LN      = 2;
    localparam int LEAD_NS = 20;
    localparam int HOLD_NS = 50;
    localparam int GAP_NS  = 100;
    localparam int LW      = $clog2(MAXB + 1);
    localparam real PER_NS = 1.0e9 / SCLK_HZ;
    localparam int NTX     = 6;

    typedef struct {
        logic [15:0] tx0, tx1, rx0, rx1;
        int          len;
        int          stall;
    } item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_valid = 1'b0;
    logic              wr_ready;
    logic [LW-1:0]     wr_len = '0;
    logic [LN*MAXB-1:0] wr_data = '0;
    logic              rd_valid;
    logic              rd_ready = 1'b0;
    logic [LN*MAXB-1:0] rd_data;
    logic [MAXB-1:0]   rd_mask;
    logic              sclk, cs_n;
    logic [LN-1:0]     sdi = '0;
    logic [LN-1:0]     sdo;

    int    checks = 0, errors = 0, done_cnt = 0;
    item_t sb_q[$];

    // Slave and capture state
    logic [15:0] cur_rx0 = '0, cur_rx1 = '0;
    int          cur_len = 1, k = 0, nbits = 0;
    logic [31:0] cap0 = '0, cap1 = '0;
    realtime     t_csfall = 0, t_rise = -1.0e6, t_fall = 0;
    bit          first_fall = 1'b0, any_rise = 1'b0;

    always #4 clk = ~clk;

    spi_hs_master #(
        .CLK_HZ(CLK_HZ), .SCLK_HZ(SCLK_HZ), .MAX_BITS(MAXB), .LANES(LN),
        .LEAD_NS(LEAD_NS), .HOLD_NS(HOLD_NS), .GAP_NS(GAP_NS)
    ) u_spi_hs_master (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_len(wr_len), .wr_data(wr_data), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .rd_data(rd_data), .rd_mask(rd_mask),
        .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .sdo(sdo)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Slave model and timing monitors
    always @(negedge cs_n) begin
        if (any_rise)
            check(($realtime - t_rise) >= GAP_NS, "R10 gap", longint'($realtime - t_rise), GAP_NS);
        t_csfall   = $realtime;
        first_fall = 1'b1;
        nbits = 0; k = 0; cap0 = '0; cap1 = '0;
    end

    always @(negedge sclk) begin
        if (!cs_n) begin
            if (first_fall)
                check(($realtime - t_csfall) >= LEAD_NS, "R8 lead", longint'($realtime - t_csfall), LEAD_NS);
            else
                check(($realtime - t_fall) >= PER_NS, "R3 period", longint'($realtime - t_fall), longint'(PER_NS));
            first_fall = 1'b0;
            t_fall = $realtime;
            if (k < cur_len) begin
                sdi[0] = cur_rx0[cur_len-1-k];
                sdi[1] = cur_rx1[cur_len-1-k];
            end
            k++;
        end
    end

    always @(posedge sclk) begin
        if (!cs_n) begin
            cap0 = {cap0[30:0], sdo[0]};
            cap1 = {cap1[30:0], sdo[1]};
            nbits++;
            t_rise = $realtime;
            any_rise = 1'b1;
        end
    end

    always @(sdo) begin
        if (!rst && !cs_n)
            check(($realtime - t_rise) >= HOLD_NS, "R9 hold", longint'($realtime - t_rise), HOLD_NS);
    end

    // Driver: pushes the expected item, then performs the write handshake
    task automatic send(input logic [15:0] tx0, input logic [15:0] tx1, input int len,
                        input logic [15:0] rx0, input logic [15:0] rx1, input int stall);
        item_t it;
        int eff;
        eff = (len == 0) ? 1 : ((len > MAXB) ? MAXB : len);
        it.tx0 = tx0; it.tx1 = tx1; it.rx0 = rx0; it.rx1 = rx1;
        it.len = eff; it.stall = stall;
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        cur_rx0 = rx0; cur_rx1 = rx1; cur_len = eff;
        sb_q.push_back(it);
        wr_valid = 1'b1;
        wr_len   = LW'(len);
        wr_data  = {tx1, tx0};
        @(negedge clk);
        wr_valid = 1'b0;
        check(!wr_ready && !cs_n, "R1 accept", {wr_ready, cs_n}, 2'b00);
    endtask

    // Monitor: pops expected items and compares with the read side
    initial begin : monitor
        item_t it;
        logic [31:0] m;
        logic [15:0] d0, d1;
        forever begin
            @(negedge clk);
            if (rd_valid) begin
                it = sb_q.pop_front();
                m  = (32'd1 << it.len) - 32'd1;
                d0 = rd_data[15:0];
                d1 = rd_data[31:16];
                for (int s = 0; s < it.stall; s++) begin
                    @(negedge clk);
                    check(rd_valid && !wr_ready && rd_data == {d1, d0}, "R2 stall hold",
                          {rd_valid, wr_ready}, 2'b10);
                end
                check(cs_n && sclk, "R3 idle lines", {cs_n, sclk}, 2'b11);
                check(nbits == it.len, "R4 edge count", nbits, it.len);
                check(rd_mask == m[15:0], "R7 mask", rd_mask, m[15:0]);
                check((cap0 & m) == ({16'd0, it.tx0} & m), "R5 lane0 order", cap0 & m, it.tx0 & m[15:0]);
                check((cap1 & m) == ({16'd0, it.tx1} & m), "R11 lane1 order", cap1 & m, it.tx1 & m[15:0]);
                check(d0 == (it.rx0 & m[15:0]), "R6 lane0 data", d0, it.rx0 & m[15:0]);
                check(d1 == (it.rx1 & m[15:0]), "R11 lane1 data", d1, it.rx1 & m[15:0]);
                rd_ready = 1'b1;
                @(negedge clk);
                rd_ready = 1'b0;
                check(!rd_valid, "R2 read done", rd_valid, 0);
                done_cnt++;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cs_n && sclk && !rd_valid, "R12 reset lines", {cs_n, sclk, rd_valid}, 3'b110);
        rst = 1'b0;
        @(negedge clk);
        check(wr_ready, "R12 ready after reset", wr_ready, 1);
        send(16'hA5C3, 16'h0F0F, 8,  16'h003C, 16'h00E1, 0);
        send(16'h0001, 16'h0000, 1,  16'h0001, 16'h0000, 3);
        send(16'hBEEF, 16'h1234, 16, 16'hC0DE, 16'h7E57, 5);
        send(16'hFFFF, 16'h0000, 0,  16'hFFFF, 16'h0000, 0);   // R4 zero length
        send(16'h8001, 16'h7FFE, 20, 16'h9669, 16'h4AB5, 2);   // R4 clamp
        send(16'h0155, 16'h02AA, 10, 16'h03FF, 16'h0000, 1);
        while (done_cnt < NTX) @(negedge clk);
        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule